// File: doc/BRIEF.md
# Key-locked RTC configuration front-end

This block sits between a register bus and the calendar of a real-time clock. It holds the calendar's configuration: the hour-format select, the alarm enable and the alarm interrupt enable, plus the two prescaler dividers. It keeps that configuration safe from stray writes behind a key register. Protection opens only when two key bytes arrive in a fixed order. Any other key value closes it again.

Software enters an initialisation phase by setting a request bit. The request is carried into the slow RTC clock domain, where it becomes the calendar's hold signal. The acknowledgement comes back to the bus domain, and only after it arrives may the prescaler be rewritten.

A second status flag reports that the calendar's shadow copies are current. Software clears it by writing zero to it. The RTC domain then performs one shadow refresh, which it cannot do while the calendar is held, and the flag rises again. The calendar counters and the alarm comparison are in a separate block.

Top module: `rtc_cfg_guard`

## Requirements
- R1: After reset: control reads 0, status reads 0x20 (only the sync flag set), prescaler reads 0x007F00FF, the key register reads 0 (locked), and `cal_init` is low.
- R2: Writing 0xCA and then 0x53 to the key register (address 0, low byte compared) unlocks protection. Bit 0 of the key register reads 1 when unlocked.
- R3: A key write other than the expected next byte locks protection. 0xCA always arms the sequence, and from the armed state any byte except 0x53 leaves protection locked.
- R4: Control (address 1) stores bits 6 (`hour12_sel`), 8 (`alarm_en`) and 12 (`alarm_irq_en`) only while unlocked. All other bits read 0.
- R5: While locked, writes to the init request bit (status address 2, bit 7) have no effect and `cal_init` stays low.
- R6: A set init request raises `cal_init` after two RTC clock edges. The acknowledge flag (status bit 6) follows after two more bus clock edges and is never seen before `cal_init` is high.
- R7: Clearing the init request drops `cal_init` and then the acknowledge flag.
- R8: The prescaler (address 3: synchronous divider in bits 14:0, asynchronous divider in bits 22:16) changes only on a write made while unlocked with the acknowledge flag set.
- R9: Writing 0 to status bit 5 clears the sync flag on the next bus cycle, whatever the lock state. The RTC domain then emits one `cal_shadow_load` pulse and the flag returns to 1. Writing 1 to bit 5 has no effect.
- R10: While `cal_init` is high, no shadow refresh happens and a cleared sync flag stays 0 until the init phase ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| rtc_clk | input | 1 | Slow RTC kernel clock |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| hour12_sel | output | 1 | Hour-format select |
| alarm_en | output | 1 | Alarm enable |
| alarm_irq_en | output | 1 | Alarm interrupt enable |
| pred_async | output | PRED_A_W | Asynchronous prescaler divider |
| pred_sync | output | PRED_S_W | Synchronous prescaler divider |
| cal_init | output | 1 | Calendar hold, RTC domain |
| cal_shadow_load | output | 1 | One-cycle shadow refresh pulse, RTC domain |

## Verification
The assertions assume that `wr_en`, `addr` and `wdata` are synchronous to `clk`. They also assume that `rtc_clk` is several times slower than `clk`, so that every level the RTC domain holds is seen by the bus-domain synchronisers, and that reset is asserted in both domains together. The stimulus changes inputs only on the falling bus edge and runs the RTC clock eight times slower, with a phase that never lines up with a bus edge. It also waits for each handshake to finish before it issues the next request of the same kind.

// File: rtl/rtc_cfg_guard.sv
`timescale 1ns/1ps
module rtc_cfg_guard #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32,
  parameter int PRED_A_W = 7,
  parameter int PRED_S_W = 15,
  parameter logic [7:0] KEY_A = 8'hCA,
  parameter logic [7:0] KEY_B = 8'h53,
  parameter logic [PRED_A_W-1:0] PRED_A_RST = 7'h7F,
  parameter logic [PRED_S_W-1:0] PRED_S_RST = 15'h00FF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rtc_clk,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                hour12_sel,
  output logic                alarm_en,
  output logic                alarm_irq_en,
  output logic [PRED_A_W-1:0] pred_async,
  output logic [PRED_S_W-1:0] pred_sync,
  output logic                cal_init,
  output logic                cal_shadow_load
);
  localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(3);
  localparam int FMT_BIT  = 6;
  localparam int ALE_BIT  = 8;
  localparam int ALIE_BIT = 12;
  localparam int RSF_BIT  = 5;
  localparam int ACK_BIT  = 6;
  localparam int REQ_BIT  = 7;
  localparam int PRED_A_LSB = 16;

  typedef enum logic [1:0] {ST_LOCK, ST_ARMED, ST_OPEN} lock_t;
  lock_t lock_q;

  logic [2:0] ctrl_q;
  logic init_req_q, req_tog;
  logic ack_s1, ack_b;
  logic dn_s1, dn_s2;
  logic ireq_s1, ireq_s2;
  logic tg_s1, tg_s2, rtc_ack_tog;
  logic [PRED_A_W-1:0] pa_q;
  logic [PRED_S_W-1:0] ps_q;

  wire unlocked = (lock_q == ST_OPEN);
  wire wr_key   = wr_en && (addr == A_KEY);
  wire wr_ctrl  = wr_en && (addr == A_CTRL);
  wire wr_stat  = wr_en && (addr == A_STAT);
  wire wr_presc = wr_en && (addr == A_PRESC);
  wire rsf_flag = (dn_s2 == req_tog);

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= ST_LOCK;
    else if (wr_key) begin
      if (lock_q == ST_ARMED && wdata[7:0] == KEY_B) lock_q <= ST_OPEN;
      else if (wdata[7:0] == KEY_A)                  lock_q <= ST_ARMED;
      else                                           lock_q <= ST_LOCK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      init_req_q <= 1'b0;
      req_tog    <= 1'b0;
      pa_q       <= PRED_A_RST;
      ps_q       <= PRED_S_RST;
    end else begin
      if (wr_ctrl && unlocked)
        ctrl_q <= {wdata[ALIE_BIT], wdata[ALE_BIT], wdata[FMT_BIT]};
      if (wr_stat && unlocked)
        init_req_q <= wdata[REQ_BIT];
      if (wr_stat && !wdata[RSF_BIT] && rsf_flag)
        req_tog <= ~req_tog;
      if (wr_presc && unlocked && ack_b) begin
        pa_q <= wdata[PRED_A_LSB +: PRED_A_W];
        ps_q <= wdata[PRED_S_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {ack_b, ack_s1, dn_s2, dn_s1} <= '0;
    else begin
      ack_s1 <= ireq_s2;
      ack_b  <= ack_s1;
      dn_s1  <= rtc_ack_tog;
      dn_s2  <= dn_s1;
    end
  end

  always_ff @(posedge rtc_clk or negedge rst_n) begin
    if (!rst_n) begin
      {ireq_s2, ireq_s1, tg_s2, tg_s1} <= '0;
      rtc_ack_tog     <= 1'b0;
      cal_shadow_load <= 1'b0;
    end else begin
      ireq_s1 <= init_req_q;
      ireq_s2 <= ireq_s1;
      tg_s1   <= req_tog;
      tg_s2   <= tg_s1;
      if (!ireq_s2 && tg_s2 != rtc_ack_tog) begin
        rtc_ack_tog     <= tg_s2;
        cal_shadow_load <= 1'b1;
      end else begin
        cal_shadow_load <= 1'b0;
      end
    end
  end

  assign cal_init     = ireq_s2;
  assign hour12_sel   = ctrl_q[0];
  assign alarm_en     = ctrl_q[1];
  assign alarm_irq_en = ctrl_q[2];
  assign pred_async   = pa_q;
  assign pred_sync    = ps_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_KEY:  rdata[0] = unlocked;
      A_CTRL: begin
        rdata[FMT_BIT]  = ctrl_q[0];
        rdata[ALE_BIT]  = ctrl_q[1];
        rdata[ALIE_BIT] = ctrl_q[2];
      end
      A_STAT: begin
        rdata[REQ_BIT] = init_req_q;
        rdata[ACK_BIT] = ack_b;
        rdata[RSF_BIT] = rsf_flag;
      end
      A_PRESC: begin
        rdata[PRED_S_W-1:0] = ps_q;
        rdata[PRED_A_LSB +: PRED_A_W] = pa_q;
      end
      default: rdata = '0;
    endcase
  end

  assert_key_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(wr_key && wdata[7:0] == KEY_B && lock_q == ST_ARMED));

  assert_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_key && wdata[7:0] != KEY_B) |=> !unlocked);

  assert_ctrl_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !unlocked) |=> $stable({alarm_irq_en, alarm_en, hour12_sel}));

  assert_req_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !unlocked) |=> $stable(rdata[REQ_BIT]) || addr != A_STAT);

  assert_presc_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_presc && !(unlocked && ack_b)) |=> $stable({pred_async, pred_sync}));

  assert_rsf_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wdata[RSF_BIT]) |=> !rsf_flag);

  assert_no_refresh_in_init_R10: assert property (@(posedge rtc_clk) disable iff (!rst_n)
    cal_shadow_load |-> $past(!cal_init));
endmodule

// File: tb/rtc_cfg_guard_tb.sv
`timescale 1ns/1ps
module rtc_cfg_guard_tb_top;
  logic clk = 1'b0, rtc_clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic hour12_sel, alarm_en, alarm_irq_en, cal_init, cal_shadow_load;
  logic [6:0] pred_async;
  logic [14:0] pred_sync;
  int checks = 0, errors = 0, shadow_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;
  initial begin #3; forever #80 rtc_clk = ~rtc_clk; end
  always @(negedge rtc_clk) if (rst_n && cal_shadow_load) shadow_cnt++;

  rtc_cfg_guard dut_i (.clk(clk), .rst_n(rst_n), .rtc_clk(rtc_clk), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .hour12_sel(hour12_sel),
    .alarm_en(alarm_en), .alarm_irq_en(alarm_irq_en), .pred_async(pred_async),
    .pred_sync(pred_sync), .cal_init(cal_init), .cal_shadow_load(cal_shadow_load));

  localparam logic [47:0] VEC [8] = '{
    {8'hCA, 8'h53, 32'hFFFF_FFFF},
    {8'h53, 8'hCA, 32'h0000_1140},
    {8'hCA, 8'hFF, 32'h0000_0040},
    {8'hCA, 8'hCA, 32'h0000_0100},
    {8'hCA, 8'h54, 32'h0000_1140},
    {8'hCB, 8'h53, 32'h0000_1140},
    {8'hCA, 8'h53, 32'h0000_0100},
    {8'hCA, 8'h53, 32'h0000_1040}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_bit(input int b, input logic v, output int n);
    logic [31:0] s;
    n = 0;
    rd(2'd2, s);
    while (s[b] !== v && n < 200) begin
      @(negedge clk); n++; rd(2'd2, s);
    end
  endtask

  task automatic unlock();
    wr(2'd0, 32'hCA); wr(2'd0, 32'h53);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int n, sc;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, r); chk("R1 key reg", r, 32'h0);
    rd(2'd1, r); chk("R1 control", r, 32'h0);
    rd(2'd2, r); chk("R1 status", r, 32'h20);
    rd(2'd3, r); chk("R1 prescaler", r, 32'h007F00FF);
    chk("R1 cal_init", {31'b0, cal_init}, 32'h0);

    for (int i = 0; i < 8; i++) begin
      logic [7:0] k0, k1;
      logic [31:0] d, exp;
      logic open;
      {k0, k1, d} = VEC[i];
      unlock(); wr(2'd1, 32'h0); wr(2'd0, 32'hFF);
      wr(2'd0, {24'h0, k0}); wr(2'd0, {24'h0, k1});
      open = (k0 == 8'hCA && k1 == 8'h53);
      rd(2'd0, r); chk("R2/R3 key state", r, {31'b0, open});
      wr(2'd1, d);
      exp = open ? (d & 32'h0000_1140) : 32'h0;
      rd(2'd1, r); chk("R4 control readback", r, exp);
      chk("R4 control pins", {29'b0, alarm_irq_en, alarm_en, hour12_sel},
          {29'b0, exp[12], exp[8], exp[6]});
    end

    unlock(); wr(2'd1, 32'h0); wr(2'd0, 32'h12);
    rd(2'd0, r); chk("R3 stray key locks", r, 32'h0);
    wr(2'd1, 32'h40); rd(2'd1, r); chk("R3 control after relock", r, 32'h0);

    wr(2'd2, 32'hA0);
    repeat (40) @(negedge clk);
    rd(2'd2, r); chk("R5 locked init request ignored", r, 32'h20);
    chk("R5 cal_init stays low", {31'b0, cal_init}, 32'h0);

    unlock();
    wr(2'd3, 32'h0005_0010);
    rd(2'd3, r); chk("R8 prescaler outside init", r, 32'h007F00FF);

    wr(2'd2, 32'hA0);
    rd(2'd2, r); chk("R6 request set, ack not yet", r & 32'hC0, 32'h80);
    wait_bit(6, 1'b1, n);
    chk("R6 ack rises in time", {31'b0, n < 200}, 32'h1);
    chk("R6 ack not immediate", {31'b0, n >= 2}, 32'h1);
    chk("R6 cal_init high with ack", {31'b0, cal_init}, 32'h1);

    wr(2'd3, 32'h0005_0010);
    rd(2'd3, r); chk("R8 prescaler in init", r, 32'h0005_0010);
    chk("R8 prescaler pins", {18'b0, pred_async, pred_sync}, {18'b0, 7'h05, 15'h0010});

    sc = shadow_cnt;
    wr(2'd2, 32'h80);
    rd(2'd2, r); chk("R9 sync flag cleared", r & 32'h20, 32'h0);
    repeat (60) @(negedge clk);
    rd(2'd2, r); chk("R10 no refresh while held", r & 32'h20, 32'h0);
    chk("R10 no shadow pulse while held", shadow_cnt, sc);

    wr(2'd2, 32'h00);
    rd(2'd2, r); chk("R7 request cleared", r & 32'h80, 32'h0);
    wait_bit(6, 1'b0, n);
    chk("R7 ack falls", {31'b0, n < 200}, 32'h1);
    chk("R7 cal_init low", {31'b0, cal_init}, 32'h0);
    wait_bit(5, 1'b1, n);
    chk("R10 sync returns after init", {31'b0, n < 200}, 32'h1);
    repeat (4) @(negedge clk);
    chk("R10 one shadow pulse", shadow_cnt, sc + 1);

    wr(2'd0, 32'hFF);
    sc = shadow_cnt;
    wr(2'd2, 32'h00);
    rd(2'd2, r); chk("R9 clear while locked", r & 32'h20, 32'h0);
    wait_bit(5, 1'b1, n);
    chk("R9 sync flag returns", {31'b0, n < 200}, 32'h1);
    repeat (4) @(negedge clk);
    chk("R9 one shadow pulse", shadow_cnt, sc + 1);
    sc = shadow_cnt;
    wr(2'd2, 32'h20);
    repeat (60) @(negedge clk);
    rd(2'd2, r); chk("R9 writing one keeps flag", r, 32'h20);
    chk("R9 writing one no pulse", shadow_cnt, sc);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule